// File: doc/BRIEF.md
# Programmable Down-Counting Timer

This block is a countdown timer that software controls through a small register bus. The bus has an address, a write strobe, write data and registered read data. Software writes a start value and picks a tick rate. The tick rate is the input clock divided by 1, 16 or 256. Software then chooses what happens when the count runs out:

- Free-running: the counter wraps to the all-ones value.
- Periodic: the counter restarts from a stored reload value.
- One-shot: the counter halts at zero.

A size bit chooses, at run time, whether the counter is 16 or 32 bits wide.

A second write port for the reload value lets software set the length of the next period. It does not disturb the count in progress. Each step of the count from one to zero sets a sticky event flag. Software clears the flag with a write of any value. An enable bit gates the flag onto a single level interrupt line.

Top module: `cdt_timer`

## Requirements
- R1: After reset, every register reads zero and irq_o is 0.
- R2: Register offsets:
  - 0x00 writes the start value and reads the reload value.
  - 0x04 reads the count.
  - 0x08 is control.
  - 0x0C clears the event flag on any write.
  - 0x10 reads the raw flag in bit 0.
  - 0x14 reads the masked flag in bit 0.
  - 0x18 writes and reads the reload value.

  Control bits: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 divider, bit 1 size (1 = 32-bit), bit 0 one-shot. Bit 4 and bits 31:8 read zero whatever was written.
- R3: While run is 1, the count steps on a tick. Divider 00 gives a tick every cycle, 01 every 16th cycle, and 10 or 11 every 256th cycle. The divider phase counts only the cycles in which run is 1.
- R4: With periodic 0 and one-shot 0, a tick at count zero sets the count to all ones. That is 0xFFFF in 16-bit size and 0xFFFFFFFF in 32-bit size.
- R5: With periodic 1 and one-shot 0, a tick at count zero loads the reload value, cut to the current size.
- R6: With one-shot 1, a tick at count zero leaves the count at zero.
- R7: In 16-bit size, only the low 16 bits of the count take part in counting. A read of 0x04 returns zero in bits 31:16.
- R8: A write to 0x00 sets both the count and the reload value to the written data at the next edge. This write takes precedence over a tick in the same cycle.
- R9: A write to 0x18 changes only the reload value. The count continues unaffected.
- R10: A tick that steps the count from 1 to 0 sets the raw flag, unless a write to 0x00 happens in the same cycle. A write to 0x0C clears the flag. When a set and a clear fall in the same cycle, the set wins.
- R11: The masked flag and irq_o both equal the raw flag ANDed with the interrupt enable bit.
- R12: While run is 0, the count and the divider phase hold their values.
- R13: rd_data_o shows the register addressed in the previous cycle, with the state it had before that cycle's edge. Offsets not listed in R2 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt, masked event flag |

## Verification
The bench builds the timer with its defaults:
- a 32-bit counter with a 16-bit narrow size;
- a prescaler whose middle tap divides by 16 and whose full length divides by 256.

These settings bring every divider setting within a short run. They also let the bench see the 16-bit wrap and the 32-bit all-ones wrap. A reload value wider than 16 bits shows the cut to size.

Small start values from the random stimulus cause frequent steps from one to zero. Together with random flag clears, these reach the case where a set and a clear fall in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFS_START = 5'h00;
  localparam logic [REG_AW-1:0] OFS_COUNT = 5'h04;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_ACK   = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_RAW   = 5'h10;
  localparam logic [REG_AW-1:0] OFS_MSK   = 5'h14;
  localparam logic [REG_AW-1:0] OFS_NEXT  = 5'h18;

  // Field order sets the bit position: first field is bit 7.
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       rsvd;
    logic [1:0] div_sel;
    logic       wide;
    logic       single;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int MID_LOG = 4,
  parameter int HI_LOG  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       tick_o
);
  logic [HI_LOG-1:0] pre_q;
  logic              mid_wrap;
  logic              hi_wrap;

  assign mid_wrap = &pre_q[MID_LOG-1:0];
  assign hi_wrap  = &pre_q;

  always_comb begin
    case (div_sel)
      2'b00:   tick_o = run;
      2'b01:   tick_o = run & mid_wrap;
      default: tick_o = run & hi_wrap;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else if (run) pre_q <= pre_q + 1'b1;
  end

  // Divided ticks never come back to back unless the divider setting changed.
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_sel != 2'b00) |=> (!tick_o || !$stable(div_sel)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wide,
  input  logic              periodic,
  input  logic              single,
  input  logic              start_we,
  input  logic [DATA_W-1:0] start_val,
  input  logic [DATA_W-1:0] reload_val,
  input  logic              ack_we,
  output logic [DATA_W-1:0] count_o,
  output logic              raw_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] cnt_d;
  logic [DATA_W-1:0] size_mask;
  logic [DATA_W-1:0] live;
  logic              hit;
  logic              raw_q;

  assign size_mask = wide ? '1 : NARROW_MASK;
  assign live      = cnt_q & size_mask;
  assign hit       = tick && (live == DATA_W'(1)) && !start_we;

  always_comb begin
    cnt_d = cnt_q;
    if (start_we) begin
      cnt_d = start_val;
    end else if (tick) begin
      if (live != '0) cnt_d = live - 1'b1;
      else if (!single) cnt_d = periodic ? (reload_val & size_mask) : size_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (hit) raw_q <= 1'b1;
      else if (ack_we) raw_q <= 1'b0;
    end
  end

  assign count_o = live;
  assign raw_o   = raw_q;

  assert_start_loads_R8: assert property (@(posedge clk) disable iff (rst)
    start_we |=> (cnt_q == $past(start_val)));
  assert_free_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && live == '0 && !single && !periodic && !start_we) |=> (cnt_q == $past(size_mask)));
  assert_single_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (single && live == '0 && !start_we) |=> (cnt_q == $past(cnt_q)));
  assert_hold_no_tick_R12: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start_we) |=> $stable(cnt_q));
  assert_flag_set_R10: assert property (@(posedge clk) disable iff (rst)
    hit |=> raw_q);
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_we && !hit) |=> !raw_q);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [tmr_pkg::REG_AW-1:0] addr,
  input  logic                       we,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [DATA_W-1:0]          count_i,
  input  logic                       raw_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       run_o,
  output logic                       periodic_o,
  output logic                       irq_en_o,
  output logic [1:0]                 div_sel_o,
  output logic                       wide_o,
  output logic                       single_o,
  output logic [DATA_W-1:0]          reload_o,
  output logic                       start_we_o,
  output logic                       ack_we_o
);
  import tmr_pkg::*;
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  ctrl_t             ctrl_wr;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  assign start_we_o = we && (addr == OFS_START);
  assign ack_we_o   = we && (addr == OFS_ACK);

  always_comb begin
    ctrl_wr      = ctrl_t'(wdata[CTRL_W-1:0]);
    ctrl_wr.rsvd = 1'b0;
  end

  always_comb begin
    case (addr)
      OFS_START, OFS_NEXT: rd_mux = reload_q;
      OFS_COUNT:           rd_mux = count_i;
      OFS_CTRL:            rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      OFS_RAW:             rd_mux = DATA_W'(raw_i);
      OFS_MSK:             rd_mux = DATA_W'(raw_i & ctrl_q.irq_en);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (we && (addr == OFS_START || addr == OFS_NEXT)) reload_q <= wdata;
      if (we && addr == OFS_CTRL) ctrl_q <= ctrl_wr;
      rdata_q <= rd_mux;
    end
  end

  assign rdata_o    = rdata_q;
  assign run_o      = ctrl_q.run;
  assign periodic_o = ctrl_q.periodic;
  assign irq_en_o   = ctrl_q.irq_en;
  assign div_sel_o  = ctrl_q.div_sel;
  assign wide_o     = ctrl_q.wide;
  assign single_o   = ctrl_q.single;
  assign reload_o   = reload_q;

  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.wide |-> (count_i[DATA_W-1:NARROW_W] == '0));
  assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == OFS_CTRL) |=> (rdata_q[DATA_W-1:CTRL_W] == '0 && rdata_q[4] == 1'b0));
  assert_next_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFS_NEXT && !run_o) |=> $stable(count_i));
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int MID_LOG  = 4,
  parameter int HI_LOG   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [tmr_pkg::REG_AW-1:0] addr_i,
  input  logic                       wr_en_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       irq_o
);
  logic              run, periodic, irq_en, wide, single;
  logic [1:0]        div_sel;
  logic [DATA_W-1:0] reload_val;
  logic [DATA_W-1:0] count_val;
  logic              start_we, ack_we, raw, tick;

  tmr_regs #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_regs (
    .clk(clk), .rst(rst), .addr(addr_i), .we(wr_en_i), .wdata(wr_data_i),
    .count_i(count_val), .raw_i(raw), .rdata_o(rd_data_o),
    .run_o(run), .periodic_o(periodic), .irq_en_o(irq_en), .div_sel_o(div_sel),
    .wide_o(wide), .single_o(single), .reload_o(reload_val),
    .start_we_o(start_we), .ack_we_o(ack_we)
  );

  tmr_prescale #(.MID_LOG(MID_LOG), .HI_LOG(HI_LOG)) u_pre (
    .clk(clk), .rst(rst), .run(run), .div_sel(div_sel), .tick_o(tick)
  );

  tmr_count #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .wide(wide), .periodic(periodic),
    .single(single), .start_we(start_we), .start_val(wr_data_i),
    .reload_val(reload_val), .ack_we(ack_we), .count_o(count_val), .raw_o(raw)
  );

  assign irq_o = raw & irq_en;

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq_o);
endmodule

// File: tb/cdt_timer_tb.sv
`timescale 1ns/1ps
module cdt_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // Reference state, from the requirements.
  logic [31:0] m_cnt, m_rel;
  logic        m_run, m_per, m_ie, m_wide, m_one, m_raw;
  logic [1:0]  m_div;
  logic [7:0]  m_pre;

  always #4 clk = ~clk;

  cdt_timer u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(we), .wr_data_i(wd),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  function automatic logic [31:0] size_mask(input logic w);
    return w ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(input logic [4:0] a);
    case (a)
      5'h00, 5'h18: return m_rel;
      5'h04:        return m_cnt & size_mask(m_wide);
      5'h08:        return {24'h0, m_run, m_per, m_ie, 1'b0, m_div, m_wide, m_one};
      5'h10:        return {31'h0, m_raw};
      5'h14:        return {31'h0, m_raw & m_ie};
      default:      return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_rel = '0; m_run = 0; m_per = 0; m_ie = 0;
    m_wide = 0; m_one = 0; m_raw = 0; m_div = '0; m_pre = '0;
  endtask

  task automatic model_step(input logic w, input logic [4:0] a, input logic [31:0] d);
    logic        tk, set, ld;
    logic [31:0] msk, live, n_cnt;
    tk = m_run && (m_div == 2'b00 || (m_div == 2'b01 && m_pre[3:0] == 4'hF) ||
                   (m_div[1] && m_pre == 8'hFF));
    msk = size_mask(m_wide);
    live = m_cnt & msk;
    ld = w && a == 5'h00;
    n_cnt = m_cnt;
    set = 0;
    if (ld) n_cnt = d;
    else if (tk) begin
      if (live != 0) begin
        n_cnt = live - 1;
        set = (live == 1);
      end else if (!m_one) n_cnt = m_per ? (m_rel & msk) : msk;
    end
    if (set) m_raw = 1;
    else if (w && a == 5'h0C) m_raw = 0;
    if (m_run) m_pre = m_pre + 1;
    m_cnt = n_cnt;
    if (w && (a == 5'h00 || a == 5'h18)) m_rel = d;
    if (w && a == 5'h08) begin
      m_run = d[7]; m_per = d[6]; m_ie = d[5];
      m_div = d[3:2]; m_wide = d[1]; m_one = d[0];
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [31:0] d);
    logic [31:0] er;
    @(negedge clk);
    addr = a; we = w; wd = d;
    er = exp_read(a);
    model_step(w, a, d);
    @(posedge clk);
    #1;
    chk(rd_data_o, er, "read");
    chk({31'h0, irq_o}, {31'h0, m_raw & m_ie}, "irq");
  endtask

  task automatic run_reads(input int n, input logic [4:0] a);
    for (int i = 0; i < n; i++) cyc(1'b0, a, 32'h0);
  endtask

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    cur_tag = "R1";
    chk(rd_data_o, 32'h0, "reset read");
    chk({31'h0, irq_o}, 32'h0, "reset irq");
    for (int a = 0; a < 8; a++) cyc(1'b0, 5'(a * 4), 32'h0);
    cyc(1'b0, 5'h1C, 32'h0);

    cur_tag = "R2";
    cyc(1'b1, 5'h08, 32'hFFFF_FF7F);
    cyc(1'b0, 5'h08, 32'h0);
    cyc(1'b1, 5'h00, 32'hA5A5_1234);
    cyc(1'b0, 5'h00, 32'h0);
    cyc(1'b0, 5'h18, 32'h0);
    cyc(1'b0, 5'h04, 32'h0);

    cur_tag = "R3";
    cyc(1'b1, 5'h08, 32'h0000_0046);
    cyc(1'b1, 5'h00, 32'd40);
    cyc(1'b1, 5'h08, 32'h0000_0086);
    run_reads(100, 5'h04);
    cyc(1'b1, 5'h08, 32'h0000_008A);
    run_reads(600, 5'h04);
    cyc(1'b1, 5'h08, 32'h0000_008E);
    run_reads(300, 5'h04);

    cur_tag = "R4";
    cyc(1'b1, 5'h08, 32'h0000_0000);
    cyc(1'b1, 5'h00, 32'd3);
    cyc(1'b1, 5'h08, 32'h0000_0080);
    run_reads(8, 5'h04);
    cyc(1'b1, 5'h00, 32'd2);
    cyc(1'b1, 5'h08, 32'h0000_0082);
    run_reads(8, 5'h04);

    cur_tag = "R5";
    cyc(1'b1, 5'h00, 32'd2);
    cyc(1'b1, 5'h08, 32'h0000_00C2);
    run_reads(12, 5'h04);

    cur_tag = "R9";
    cyc(1'b1, 5'h18, 32'd6);
    run_reads(4, 5'h04);
    cyc(1'b0, 5'h18, 32'h0);
    run_reads(14, 5'h04);

    cur_tag = "R6";
    cyc(1'b1, 5'h00, 32'd4);
    cyc(1'b1, 5'h08, 32'h0000_00A3);
    run_reads(10, 5'h04);
    cyc(1'b0, 5'h10, 32'h0);

    cur_tag = "R7";
    cyc(1'b1, 5'h08, 32'h0000_0040);
    cyc(1'b1, 5'h00, 32'h0001_0003);
    cyc(1'b0, 5'h04, 32'h0);
    cyc(1'b1, 5'h18, 32'h0001_2345);
    cyc(1'b1, 5'h08, 32'h0000_00C0);
    run_reads(8, 5'h04);

    cur_tag = "R8";
    cyc(1'b1, 5'h00, 32'd9);
    cyc(1'b1, 5'h00, 32'd1);
    run_reads(3, 5'h04);

    cur_tag = "R10";
    cyc(1'b1, 5'h08, 32'h0000_0022);
    cyc(1'b1, 5'h0C, 32'h0);
    cyc(1'b1, 5'h00, 32'd2);
    cyc(1'b1, 5'h08, 32'h0000_00A2);
    cyc(1'b0, 5'h10, 32'h0);
    cyc(1'b1, 5'h0C, 32'hDEAD_BEEF);
    cyc(1'b0, 5'h10, 32'h0);
    cyc(1'b1, 5'h0C, 32'h0);
    cyc(1'b0, 5'h10, 32'h0);

    cur_tag = "R11";
    cyc(1'b1, 5'h00, 32'd1);
    cyc(1'b1, 5'h08, 32'h0000_0082);
    run_reads(3, 5'h14);
    cyc(1'b1, 5'h08, 32'h0000_00A2);
    run_reads(3, 5'h14);

    cur_tag = "R12";
    cyc(1'b1, 5'h08, 32'h0000_0006);
    cyc(1'b1, 5'h00, 32'd50);
    run_reads(40, 5'h04);
    cyc(1'b1, 5'h08, 32'h0000_0086);
    run_reads(40, 5'h04);

    cur_tag = "R13";
    cyc(1'b0, 5'h1C, 32'h0);
    cyc(1'b0, 5'h01, 32'h0);
    cyc(1'b0, 5'h1F, 32'h0);
    cyc(1'b1, 5'h1C, 32'hFFFF_FFFF);
    cyc(1'b0, 5'h08, 32'h0);

    cur_tag = "R2";
    void'($urandom(32'd20240));
    for (int i = 0; i < 4000; i++) begin
      logic [4:0]  a;
      logic [31:0] d;
      logic        w;
      a = 5'($urandom_range(0, 7) * 4);
      w = ($urandom_range(0, 9) < 3);
      d = $urandom();
      if (a == 5'h00 || a == 5'h18) d = ($urandom_range(0, 7) == 0) ? d : (d & 32'h3F);
      if (a == 5'h08) d[7] = ($urandom_range(0, 3) != 0);
      if (w && a == 5'h00 && $urandom_range(0, 2) != 0) w = 1'b0;
      cyc(w, a, d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL %s watchdog expired", cur_tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule